// File: doc/BRIEF.md
# Soft Processor Restart Controller

This block decides when an embedded 8-bit soft processor is restarted between packets, and what it runs after the restart. The processor reports the end of its work on a packet with a done pulse. If a stored data packet is then available, the controller raises the processor's interrupt input for a fixed two-cycle pulse. That pulse serves as the restart.

At the edge that starts the pulse, the controller makes two choices. First, it picks the program bank. When the store logic reports that a freshly loaded program is waiting, the controller swaps the two program banks and sends back a one-cycle clear for that flag. Otherwise it keeps the current program bank. Second, it moves the data bank select to the next of the four data banks. This lets the program change from one packet to the next.

After reset, the controller waits for the first data packet and starts the processor on program bank 0 and data bank 0. A done signal that arrives while no data is available parks the controller in a waiting state until data shows up.

Top module: `sp_restart_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `irq_out` and `new_prog_clr` are 0, and `prog_bank` and `data_bank` are both 0.
- R2: Each restart drives `irq_out` high for exactly two consecutive cycles. The first high cycle follows the rising clock edge at which the restart condition was sampled.
- R3: After reset, the first restart happens as soon as data is available, without any done pulse. Any done pulse seen before that has no effect. The first restart keeps `data_bank` at 0.
- R4: Every later restart increments `data_bank` by one, modulo 4 (3 goes to 0). The change happens at the same edge where `irq_out` rises.
- R5: A done pulse seen while no data is available produces no pulse. The controller then waits, and restarts (with a data bank step) at the first edge at which data is available.
- R6: A restart sampled with `new_prog_flag` = 0 leaves `prog_bank` unchanged.
- R7: A restart sampled with `new_prog_flag` = 1 toggles `prog_bank` (0 becomes 1, 1 becomes 0) at the edge where `irq_out` rises. `new_prog_clr` is 1 during the first pulse cycle only and 0 at all other times.
- R8: A done pulse sampled while a restart pulse is in progress is ignored. It causes no extra pulse and no bank change.
- R9: Data counts as available only when `data_pend` = 1 and `data_count` is nonzero. Outside a pulse, `prog_bank` and `data_bank` never change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| proc_done | input | 1 | Processor has finished its current data packet |
| new_prog_flag | input | 1 | Store logic holds a newly loaded program in the alternate bank |
| data_pend | input | 1 | Store logic reports a data packet pending |
| data_count | input | CNT_W (3) | Number of stored data packets |
| irq_out | output | 1 | Restart pulse to the processor interrupt input |
| new_prog_clr | output | 1 | One-cycle clear of the new-program flag |
| prog_bank | output | PB_W (1) | Current program bank select |
| data_bank | output | DB_W (2) | Current data bank select |

## Verification
Three actions can all land on one launching edge: the program bank swap with its flag clear, and the data bank step. The bench provokes this by raising `new_prog_flag` in the same cycle as `proc_done`. A scoreboard entry then carries the expected program bank, data bank and clear value, and the monitor compares all three in the first pulse cycle.

A second collision is a done pulse held across both pulse cycles. That case is judged by the absence of an unexpected pulse. It is also judged by the following restart, which must step the data bank by exactly one.

// File: rtl/sp_restart_pkg.sv
package sp_restart_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_WAIT = 2'd2
  } ctl_state_e;

  // next bank index in a ring of n banks
  function automatic int unsigned ring_next(int unsigned cur, int unsigned n);
    return (cur + 1 >= n) ? 0 : cur + 1;
  endfunction

  // a packet is ready when the flag is set and the store holds something
  function automatic logic data_ready(logic pend, int unsigned cnt);
    return pend && (cnt != 0);
  endfunction

endpackage

// File: rtl/sp_bank_ptr.sv
module sp_bank_ptr #(
  parameter int NUM = 4,
  localparam int SW = (NUM > 1) ? $clog2(NUM) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  output logic [SW-1:0] sel
);
  import sp_restart_pkg::*;

  logic [SW-1:0] sel_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    sel_q <= '0;
    else if (step) sel_q <= SW'(ring_next(32'(sel_q), NUM));
  end

  assign sel = sel_q;

  p_ptr_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    32'(sel_q) < NUM);
endmodule

// File: rtl/sp_pulse_gen.sv
module sp_pulse_gen #(
  parameter int LEN = 2,
  localparam int CW = $clog2(LEN + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt_q <= '0;
    else if (start)      cnt_q <= CW'(LEN);
    else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != 0);

  p_no_start_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
endmodule

// File: rtl/sp_restart_fsm.sv
module sp_restart_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic done,
  input  logic avail,
  input  logic busy,
  output logic launch,
  output logic advance
);
  import sp_restart_pkg::*;

  ctl_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    launch  = 1'b0;
    advance = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (avail) begin
          launch  = 1'b1;
          state_d = ST_RUN;
        end
      end
      ST_RUN: begin
        if (done && !busy) begin
          if (avail) begin
            launch  = 1'b1;
            advance = 1'b1;
          end else begin
            state_d = ST_WAIT;
          end
        end
      end
      ST_WAIT: begin
        if (avail && !busy) begin
          launch  = 1'b1;
          advance = 1'b1;
          state_d = ST_RUN;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  p_idle_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |=> (state_q != ST_IDLE));
  p_adv_has_launch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    advance |-> launch);
endmodule

// File: rtl/sp_restart_ctrl.sv
module sp_restart_ctrl #(
  parameter int NUM_PROG_BANKS = 2,
  parameter int NUM_DATA_BANKS = 4,
  parameter int CNT_W          = 3,
  parameter int PULSE_CYCLES   = 2,
  localparam int PB_W = (NUM_PROG_BANKS > 1) ? $clog2(NUM_PROG_BANKS) : 1,
  localparam int DB_W = (NUM_DATA_BANKS > 1) ? $clog2(NUM_DATA_BANKS) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            proc_done,
  input  logic            new_prog_flag,
  input  logic            data_pend,
  input  logic [CNT_W-1:0] data_count,
  output logic            irq_out,
  output logic            new_prog_clr,
  output logic [PB_W-1:0] prog_bank,
  output logic [DB_W-1:0] data_bank
);
  import sp_restart_pkg::*;

  // named internal events
  logic avail;
  logic launch;
  logic advance;
  logic busy;
  logic swap_now;
  logic clr_q;

  assign avail    = data_ready(data_pend, 32'(data_count));
  assign swap_now = launch && new_prog_flag;

  sp_restart_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .done    (proc_done),
    .avail   (avail),
    .busy    (busy),
    .launch  (launch),
    .advance (advance)
  );

  sp_pulse_gen #(.LEN(PULSE_CYCLES)) u_pulse (
    .clk   (clk),
    .rst_n (rst_n),
    .start (launch),
    .busy  (busy)
  );

  sp_bank_ptr #(.NUM(NUM_PROG_BANKS)) u_prog_ptr (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (swap_now),
    .sel   (prog_bank)
  );

  sp_bank_ptr #(.NUM(NUM_DATA_BANKS)) u_data_ptr (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (advance),
    .sel   (data_bank)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) clr_q <= 1'b0;
    else        clr_q <= swap_now;
  end

  assign irq_out      = busy;
  assign new_prog_clr = clr_q;

  p_pulse_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_out) |=> irq_out);

  generate
    if (PULSE_CYCLES == 2) begin : g_len2
      p_pulse_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out && $past(irq_out)) |=> !irq_out);
    end
  endgenerate

  p_prog_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(irq_out) |-> $stable(prog_bank));
  p_data_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(irq_out) |-> $stable(data_bank));
  p_clr_with_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    new_prog_clr |-> $rose(irq_out));
  p_start_needs_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_out) |-> $past(avail));
endmodule

// File: tb/sim_sp_restart_ctrl.sv
`timescale 1ns/1ps
module sim_sp_restart_ctrl;
  localparam int CNT_W = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic proc_done, new_prog_flag, data_pend;
  logic [CNT_W-1:0] data_count;
  logic irq_out, new_prog_clr;
  logic [0:0] prog_bank;
  logic [1:0] data_bank;

  always #4 clk = ~clk;

  sp_restart_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .proc_done(proc_done), .new_prog_flag(new_prog_flag),
    .data_pend(data_pend), .data_count(data_count), .irq_out(irq_out),
    .new_prog_clr(new_prog_clr), .prog_bank(prog_bank), .data_bank(data_bank)
  );

  typedef struct packed { logic prog; logic [1:0] data; logic clr; } exp_t;
  exp_t sb_q[$];

  int checks = 0;
  int errors = 0;
  int e_prog = 0;
  int e_data = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // monitor: pops expected pulses and checks lengths and stability
  logic prev_irq = 1'b0;
  int   plen = 0;
  int   last_prog = 0;
  int   last_data = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (irq_out && !prev_irq) begin
        if (sb_q.size() == 0) begin
          chk(1'b0, "R8", "unexpected pulse", 1, 0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          chk(prog_bank == e.prog, "R6/R7", "prog_bank", int'(prog_bank), int'(e.prog));
          chk(data_bank == e.data, "R3/R4", "data_bank", int'(data_bank), int'(e.data));
          chk(new_prog_clr == e.clr, "R7", "new_prog_clr", int'(new_prog_clr), int'(e.clr));
        end
        plen = 1;
      end else begin
        chk(int'(prog_bank) == last_prog, "R9", "prog_bank stable", int'(prog_bank), last_prog);
        chk(int'(data_bank) == last_data, "R9", "data_bank stable", int'(data_bank), last_data);
        chk(new_prog_clr == 1'b0, "R7", "clr outside first cycle", int'(new_prog_clr), 0);
        if (irq_out) plen++;
        if (!irq_out && prev_irq) chk(plen == 2, "R2", "pulse length", plen, 2);
      end
      last_prog = int'(prog_bank);
      last_data = int'(data_bank);
      prev_irq  = irq_out;
    end
  end

  // watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      chk(1'b0, "WDOG", "run timeout", cyc, 20000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic push(input int swap, input bit adv);
    exp_t e;
    e_prog = e_prog ^ swap;
    if (adv) e_data = (e_data + 1) % 4;
    e.prog = e_prog[0];
    e.data = e_data[1:0];
    e.clr  = swap[0];
    sb_q.push_back(e);
  endtask

  task automatic restart(input int swap);
    proc_done = 1'b1;
    new_prog_flag = swap[0];
    push(swap, 1'b1);
    tick();
    proc_done = 1'b0;
    new_prog_flag = 1'b0;
    repeat (4) tick();
  endtask

  initial begin
    rst_n = 1'b0; proc_done = 1'b0; new_prog_flag = 1'b0;
    data_pend = 1'b0; data_count = '0;
    repeat (3) tick();
    // R1 reset state
    chk(irq_out == 1'b0, "R1", "irq in reset", int'(irq_out), 0);
    chk(new_prog_clr == 1'b0, "R1", "clr in reset", int'(new_prog_clr), 0);
    chk(prog_bank == 1'b0, "R1", "prog_bank in reset", int'(prog_bank), 0);
    chk(data_bank == 2'd0, "R1", "data_bank in reset", int'(data_bank), 0);
    rst_n = 1'b1;
    tick();
    chk(irq_out == 1'b0, "R1", "irq after reset", int'(irq_out), 0);

    // R3: done pulses in idle with no data do nothing
    proc_done = 1'b1;
    repeat (3) tick();
    proc_done = 1'b0;
    // R9: pend without count is not data
    data_pend = 1'b1;
    repeat (4) tick();
    chk(irq_out == 1'b0, "R9", "no pulse with zero count", int'(irq_out), 0);
    // R3: first start, bank 0
    data_count = 3'd2;
    push(0, 1'b0);
    tick();
    repeat (4) tick();

    restart(0);   // R6 data 1
    restart(1);   // R7 swap, data 2
    restart(1);   // R7 swap back, data 3
    restart(0);   // R4 wrap to 0

    // R8: done held through the pulse
    proc_done = 1'b1;
    push(0, 1'b1);
    tick(); tick(); tick();
    proc_done = 1'b0;
    repeat (4) tick();
    restart(1);   // single step after ignored done

    // R5: done with nothing pending, then data arrives
    data_pend = 1'b0; data_count = '0;
    proc_done = 1'b1;
    tick();
    proc_done = 1'b0;
    repeat (5) tick();
    chk(irq_out == 1'b0, "R5", "no pulse while waiting", int'(irq_out), 0);
    data_pend = 1'b1; data_count = 3'd1;
    push(0, 1'b1);
    tick();
    repeat (4) tick();

    // R9: pend high but zero count while running, then count arrives
    data_count = '0;
    proc_done = 1'b1;
    tick();
    proc_done = 1'b0;
    repeat (3) tick();
    chk(irq_out == 1'b0, "R9", "no pulse pend only", int'(irq_out), 0);
    new_prog_flag = 1'b1;
    data_count = 3'd3;
    push(1, 1'b1);
    tick();
    new_prog_flag = 1'b0;
    repeat (4) tick();

    chk(sb_q.size() == 0, "R2", "pulses outstanding", sb_q.size(), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule